// File: doc/BRIEF.md
# Binary-Tree Peripheral ID Mapper

This block turns a 12-bit peripheral identifier into an 8-bit allocated index by walking a binary decision tree held in a local table. The identifier is the concatenation of a 4-bit slave number (upper bits) and an 8-bit peripheral number (lower bits).

Each table word is a decision node. The node names one identifier bit to test, and gives two branches, one for a 0 and one for a 1. Each branch either points to another node or carries the final index. The walk starts at node 0 and advances one node per clock. It ends with a found result, or with not-found if it runs out of steps or follows a pointer outside the table.

A single write port loads the table. A start pulse launches a lookup. The block answers with a one-cycle done pulse, a found flag and the index.

Top module: `ppid_tree_mapper`

## Requirements
- R1: After reset, done, found and result are all 0.
- R2: The identifier is {slave, peripheral}, so bit 11 is the top slave bit and bit 0 is the lowest peripheral bit. A node that tests bit positions 12 to 15 sees a 0.
- R3: A node word is 22 bits wide:
  - bits 21:18 hold the bit position to test;
  - bit 17 and bits 16:8+1 hold the flag and value of the 0 branch;
  - bit 8 and bits 7:0 hold the flag and value of the 1 branch.
- R4: The walk starts at node 0. A taken branch whose flag is 1 moves to the node its value names. A taken branch whose flag is 0 ends the walk with found=1 and result equal to that value.
- R5: The block takes one clock per node visited. If a start is sampled on clock edge E and the walk visits k nodes, done is high after edge E+k.
- R6: done is high for exactly one cycle. found and result change only on that cycle and then hold until the next done.
- R7: A walk that has visited 16 nodes without reaching a result ends with done, found=0 and result=0, 16 cycles after start.
- R8: A taken pointer whose value is 255 or more (outside the 255-entry table) ends the walk at that node with found=0 and result=0.
- R9: A start that arrives while a walk is in progress is ignored. It does not change the running walk and does not cause a further done.
- R10: A write stores wr_data at wr_addr, and later walks use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a lookup (one-cycle pulse) |
| sid_in | input | 4 | Slave number of the identifier |
| pnum_in | input | 8 | Peripheral number of the identifier |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 8 | Table entry to write |
| wr_data | input | 22 | Node word to store |
| done | output | 1 | Lookup finished (one cycle) |
| found | output | 1 | Lookup produced an index |
| result | output | 8 | Resulting index, 0 when not found |

## Verification
The bench builds small trees and checks the exact done latency at depths 1, 2 and 3. A design with a pipeline bubble, or one that skips node 0, would answer late or with the wrong index.

A self-looping chain checks that the walk gives up after 16 visits. An off-by-one counter would stop after 15 or 17 visits. A node pointing to 255 must end the walk at once, and a design that dereferences it would read garbage.

The bench also targets:
- A node that tests bit 14, which must read as 0. A design that indexes the wrong field or sign-extends would pick the wrong branch.
- A start raised in the middle of a walk, which must neither restart the walk nor add a second done.
- Rewriting a node between walks, which must change the later result.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  localparam int SEL_W   = 4;
  localparam int RES_W   = 8;
  localparam int ENTRY_W = SEL_W + 2 * (RES_W + 1);
  localparam int TEST_W  = 2 ** SEL_W;

  typedef struct packed {
    logic             is_ptr;
    logic [RES_W-1:0] val;
  } branch_t;

  // bit position tested by a node word
  function automatic logic [SEL_W-1:0] node_sel(input logic [ENTRY_W-1:0] w);
    return w[ENTRY_W-1 -: SEL_W];
  endfunction

  // branch taken for the given bit value
  function automatic branch_t node_branch(input logic [ENTRY_W-1:0] w,
                                          input logic bit_val);
    branch_t b;
    if (bit_val) begin
      b.is_ptr = w[RES_W];
      b.val    = w[RES_W-1:0];
    end else begin
      b.is_ptr = w[2*RES_W+1];
      b.val    = w[2*RES_W:RES_W+1];
    end
    return b;
  endfunction
endpackage

// File: rtl/ptm_node_table.sv
module ptm_node_table #(
  parameter int DEPTH  = 255,
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [ptm_pkg::ENTRY_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [ptm_pkg::ENTRY_W-1:0]  rd_data
);
  logic [ptm_pkg::ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;
  end

  always_comb begin
    if (int'(rd_addr) < DEPTH) rd_data = mem[rd_addr];
    else rd_data = '0;
  end
endmodule

// File: rtl/ptm_branch_eval.sv
module ptm_branch_eval #(
  parameter int ID_W = 12
) (
  input  logic [ptm_pkg::ENTRY_W-1:0] node_word,
  input  logic [ID_W-1:0]             id,
  output logic                        tested_bit,
  output ptm_pkg::branch_t            branch
);
  import ptm_pkg::*;
  logic [TEST_W-1:0] id_ext;

  always_comb begin
    id_ext     = TEST_W'(id);
    tested_bit = id_ext[node_sel(node_word)];
    branch     = node_branch(node_word, tested_bit);
  end
endmodule

// File: rtl/ptm_walk_ctrl.sv
module ptm_walk_ctrl #(
  parameter int ID_W      = 12,
  parameter int ADDR_W    = 8,
  parameter int DEPTH     = 255,
  parameter int MAX_STEPS = 16,
  parameter int STEP_W    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [ID_W-1:0]           id_in,
  input  ptm_pkg::branch_t          branch,
  output logic [ADDR_W-1:0]         node,
  output logic [ID_W-1:0]           id_q,
  output logic [STEP_W-1:0]         step,
  output logic                      busy,
  output logic                      hit_evt,
  output logic                      miss_evt,
  output logic                      hop_evt,
  output logic                      done,
  output logic                      found,
  output logic [ptm_pkg::RES_W-1:0] result
);
  logic ptr_bad, last_step, start_acc;

  always_comb begin
    ptr_bad   = branch.is_ptr && (int'(branch.val) >= DEPTH);
    last_step = (int'(step) == MAX_STEPS - 1);
    start_acc = start && !busy;
    hit_evt   = busy && !branch.is_ptr;
    miss_evt  = busy && branch.is_ptr && (ptr_bad || last_step);
    hop_evt   = busy && branch.is_ptr && !ptr_bad && !last_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      node   <= '0;
      step   <= '0;
      id_q   <= '0;
      done   <= 1'b0;
      found  <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (start_acc) begin
        busy <= 1'b1;
        id_q <= id_in;
        node <= '0;
        step <= '0;
      end else if (hit_evt) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        found  <= 1'b1;
        result <= branch.val;
      end else if (miss_evt) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        found  <= 1'b0;
        result <= '0;
      end else if (hop_evt) begin
        node <= ADDR_W'(branch.val);
        step <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ppid_tree_mapper.sv
module ppid_tree_mapper #(
  parameter int SID_W     = 4,
  parameter int PNUM_W    = 8,
  parameter int TBL_DEPTH = 255,
  parameter int MAX_STEPS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [SID_W-1:0]            sid_in,
  input  logic [PNUM_W-1:0]           pnum_in,
  input  logic                        wr_en,
  input  logic [7:0]                  wr_addr,
  input  logic [ptm_pkg::ENTRY_W-1:0] wr_data,
  output logic                        done,
  output logic                        found,
  output logic [ptm_pkg::RES_W-1:0]   result
);
  localparam int ID_W   = SID_W + PNUM_W;
  localparam int ADDR_W = 8;
  localparam int STEP_W = $clog2(MAX_STEPS + 1);

  logic [ID_W-1:0]             walk_id;
  logic [ADDR_W-1:0]           walk_node;
  logic [STEP_W-1:0]           walk_step;
  logic                        walk_busy, hit_evt, miss_evt, hop_evt, tested_bit;
  logic [ptm_pkg::ENTRY_W-1:0] node_word;
  ptm_pkg::branch_t            branch;

  ptm_node_table #(.DEPTH(TBL_DEPTH), .ADDR_W(ADDR_W)) table_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(walk_node), .rd_data(node_word)
  );

  ptm_branch_eval #(.ID_W(ID_W)) eval_i (
    .node_word(node_word), .id(walk_id), .tested_bit(tested_bit), .branch(branch)
  );

  ptm_walk_ctrl #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .DEPTH(TBL_DEPTH),
    .MAX_STEPS(MAX_STEPS), .STEP_W(STEP_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .id_in({sid_in, pnum_in}),
    .branch(branch), .node(walk_node), .id_q(walk_id), .step(walk_step),
    .busy(walk_busy), .hit_evt(hit_evt), .miss_evt(miss_evt), .hop_evt(hop_evt),
    .done(done), .found(found), .result(result)
  );
endmodule

// File: rtl/ptm_checker.sv
module ptm_checker #(
  parameter int TBL_DEPTH = 255,
  parameter int MAX_STEPS = 16,
  parameter int ID_W      = 12,
  parameter int STEP_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              found,
  input logic [7:0]        result,
  input logic              busy,
  input logic [STEP_W-1:0] step,
  input logic [7:0]        node,
  input logic [ID_W-1:0]   id
);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(found) && $stable(result)));
  // R5
  done_ends_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  // R4
  walk_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (node == 8'd0 && step == '0));
  // R7
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(step) < MAX_STEPS));
  // R8
  node_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(node) < TBL_DEPTH));
  // R9
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(id));
  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (result == 8'd0));
endmodule

bind ppid_tree_mapper ptm_checker #(
  .TBL_DEPTH(TBL_DEPTH), .MAX_STEPS(MAX_STEPS), .ID_W(ID_W), .STEP_W(STEP_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .found(found), .result(result),
  .busy(walk_busy), .step(walk_step), .node(walk_node), .id(walk_id)
);

// File: tb/ppid_tree_mapper_tb_top.sv
module ppid_tree_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  sid_i = '0;
  logic [7:0]  pnum_i = '0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [21:0] wr_data_i = '0;
  logic        done_o, found_o;
  logic [7:0]  result_o;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ppid_tree_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .start(start_i), .sid_in(sid_i), .pnum_in(pnum_i),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .done(done_o), .found(found_o), .result(result_o)
  );

  // node word: [21:18] bit, [17] zero-flag, [16:9] zero-val, [8] one-flag, [7:0] one-val
  function automatic logic [21:0] mk(input int b, input bit f0, input int v0,
                                     input bit f1, input int v1);
    return {4'(b), f0, 8'(v0), f1, 8'(v1)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [21:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 8'(a); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic run_walk(input string req, input int s, input int p,
                          input bit exp_f, input int exp_r, input int exp_lat);
    int n;
    @(negedge clk);
    sid_i = 4'(s); pnum_i = 8'(p); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 100) begin @(negedge clk); n++; end
    chk({req, " latency"}, n, exp_lat);
    chk({req, " found"}, int'(found_o), int'(exp_f));
    chk({req, " result"}, int'(result_o), exp_r);
    @(negedge clk);
    chk("R6 done one cycle", int'(done_o), 0);
    chk("R6 result held", int'(result_o), exp_r);
  endtask

  task automatic t_reset;
    chk("R1 done", int'(done_o), 0);
    chk("R1 found", int'(found_o), 0);
    chk("R1 result", int'(result_o), 0);
  endtask

  task automatic t_load_tree;
    wr(0, mk(11, 1'b1, 1, 1'b0, 8'h80));
    wr(1, mk(0, 1'b0, 8'h11, 1'b1, 2));
    wr(2, mk(14, 1'b0, 8'h22, 1'b0, 8'h33));
  endtask

  task automatic t_busy_ignore;
    int n;
    int extra;
    @(negedge clk);
    sid_i = 4'h0; pnum_i = 8'h01; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 100) begin
      @(negedge clk); n++;
      if (n == 1) begin sid_i = 4'h8; start_i = 1'b1; end
      if (n == 2) start_i = 1'b0;
    end
    chk("R9 latency unchanged", n, 3);
    chk("R9 result of first walk", int'(result_o), 8'h22);
    extra = 0;
    repeat (20) begin @(negedge clk); if (done_o) extra++; end
    chk("R9 no extra done", extra, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_tree();
    run_walk("R4 R2 leaf at root", 8, 8'h00, 1'b1, 8'h80, 1);
    run_walk("R5 R3 depth two", 0, 8'h00, 1'b1, 8'h11, 2);
    run_walk("R2 high bit reads zero", 0, 8'h01, 1'b1, 8'h22, 3);
    t_busy_ignore();
    wr(2, mk(0, 1'b0, 8'h44, 1'b0, 8'h55));
    run_walk("R10 rewritten node", 0, 8'h01, 1'b1, 8'h55, 3);
    wr(5, mk(0, 1'b1, 5, 1'b1, 5));
    wr(0, mk(3, 1'b1, 5, 1'b1, 5));
    run_walk("R7 step limit", 0, 8'h00, 1'b0, 0, 16);
    wr(6, mk(0, 1'b1, 255, 1'b1, 255));
    wr(0, mk(3, 1'b1, 6, 1'b1, 6));
    run_walk("R8 pointer outside", 0, 8'h00, 1'b0, 0, 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule